// File: doc/BRIEF.md
# I2C Bus-Hang Recovery Sequencer

This block runs once, before the I2C controller is set up, to free a bus that an interrupted transfer left stuck. When started, it first gives the controller's busy indication a bounded time to clear. It looks at busy as soon as it starts and then once per millisecond, for a configurable number of milliseconds. It then decides whether recovery is needed. Recovery is needed when busy is still set after that wait, or when the synchronized data line reads low.

During recovery the block takes both bus pins away from the controller and drives the clock line itself at a slow millisecond pace. After each pulse it checks the data line, and it stops as soon as the slave lets go. It gives up after a bounded number of pulses. It ends with the clock line high and hands the pins back to the controller. It then holds `done_o` until the next start. It raises `fail_o` with `done_o` if the data line never came free.

The millisecond length is a parameter in clock cycles, so the same RTL serves any system clock.

Top module: `i2c_hang_recover`

## Requirements
- R1: After reset, `scl_o` is 1 and `pin_sel_o`, `done_o` and `fail_o` are 0.
- R2: Busy is checked at start and then once every MS_CYCLES-plus-one cycles, for at most BUSY_POLLS waits. If busy clears while the data line is high, the block ends with `done_o`=1 and `fail_o`=0, never having set `pin_sel_o`. It does so no later than one check period after busy falls.
- R3: When busy is still 1 after the full wait, or the data line reads low at the decision, `pin_sel_o` rises (1 = pins under direct control). With busy held high, this happens between BUSY_POLLS*MS_CYCLES and BUSY_POLLS*(MS_CYCLES+1)+4 cycles after start.
- R4: On takeover, `scl_o` is 0 in the same cycle that `pin_sel_o` rises. The first low phase lasts MS_CYCLES+1 cycles before the first data-line check ends it.
- R5: Every high phase of `scl_o` while `pin_sel_o`=1 lasts exactly MS_CYCLES cycles. Every low phase lasts exactly MS_CYCLES+1 cycles: one millisecond plus the check cycle.
- R6: The data line is sampled through a two-flop synchronizer, once per check. Pulsing stops at the first check that sees it high. If the slave releases after N clock pulses, exactly min(N, MAX_PULSES) pulses are issued.
- R7: After the last check, `scl_o` is held high for MS_CYCLES cycles. Then `pin_sel_o` falls and `done_o` rises in the same cycle. `scl_o` is 1 whenever `pin_sel_o` is 0.
- R8: If the data line is still low at the check after MAX_PULSES pulses, `fail_o`=1 together with `done_o`. Otherwise `fail_o`=0, including when the release is seen at exactly that last check. `fail_o` is never 1 without `done_o`.
- R9: `start_i` is ignored while a sequence is in progress. `done_o` and `fail_o` hold until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence (sampled when idle or done) |
| busy_i | input | 1 | Bus-busy indication from the controller |
| sda_i | input | 1 | Raw data-line pin level |
| scl_o | output | 1 | Clock-line drive level while pins are under direct control |
| pin_sel_o | output | 1 | 1 = pins under direct control, 0 = pins owned by controller |
| done_o | output | 1 | Sequence complete, pins returned |
| fail_o | output | 1 | Data line still low after the last allowed pulse |

## Verification
The critical coincidence is the final allowed check landing on the same cycle the slave releases the data line. At that check the pulse limit and the release decide the outcome together. The bench sweeps the release point across the limit: release after 9, 10, 11 and 12 pulses. It expects 10 pulses and no fail for release at 10, and 10 pulses with fail for 11 and beyond. The second pairing is `start_i` arriving mid-recovery while a pulse is in flight. That start must leave the pulse count and the single completion unchanged.

// File: rtl/i2c_hang_recover_pkg.sv
package i2c_hang_recover_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_POLL_WAIT,
    ST_DECIDE,
    ST_LOW0,
    ST_CHECK,
    ST_HIGH,
    ST_LOW,
    ST_RELEASE,
    ST_DONE
  } hr_state_e;
endpackage

// File: rtl/hr_sync2.sv
module hr_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/hr_ms_timer.sv
module hr_ms_timer #(
  parameter int unsigned MS_CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (MS_CYCLES > 2) ? $clog2(MS_CYCLES) : 1;
  localparam logic [W-1:0] LAST = W'(MS_CYCLES - 1);

  logic [W-1:0] cnt_q;

  // held at zero outside wait states; wraps so back-to-back waits stay aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  // R5
  ms_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/hr_step_counter.sv
module hr_step_counter #(
  parameter int unsigned MAX = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_max_o
);
  localparam int unsigned W = $clog2(MAX + 1);
  localparam logic [W-1:0] LIMIT = W'(MAX);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign at_max_o = (cnt_q == LIMIT);

  // R6
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
endmodule

// File: rtl/i2c_hang_recover.sv
module i2c_hang_recover
  import i2c_hang_recover_pkg::*;
#(
  parameter int unsigned MS_CYCLES  = 50000,
  parameter int unsigned BUSY_POLLS = 1000,
  parameter int unsigned MAX_PULSES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic busy_i,
  input  logic sda_i,
  output logic scl_o,
  output logic pin_sel_o,
  output logic done_o,
  output logic fail_o
);
  hr_state_e state_q, state_d;
  logic sda_s, tick, timer_en;
  logic poll_clr, poll_inc, poll_max;
  logic pulse_clr, pulse_inc, pulse_max;
  logic fail_q, fail_d;

  hr_sync2 #(.RESET_VAL(1'b1)) u_sda_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (sda_i), .q_o (sda_s)
  );

  hr_ms_timer #(.MS_CYCLES(MS_CYCLES)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (timer_en), .tick_o (tick)
  );

  hr_step_counter #(.MAX(BUSY_POLLS)) u_poll_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (poll_clr), .inc_i (poll_inc),
    .at_max_o (poll_max)
  );

  hr_step_counter #(.MAX(MAX_PULSES)) u_pulse_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (pulse_clr), .inc_i (pulse_inc),
    .at_max_o (pulse_max)
  );

  assign timer_en = (state_q == ST_POLL_WAIT) || (state_q == ST_LOW0) ||
                    (state_q == ST_HIGH) || (state_q == ST_LOW) ||
                    (state_q == ST_RELEASE);

  always_comb begin
    state_d   = state_q;
    fail_d    = fail_q;
    poll_clr  = 1'b0;
    poll_inc  = 1'b0;
    pulse_clr = 1'b0;
    pulse_inc = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) begin
        state_d  = ST_POLL;
        poll_clr = 1'b1;
        fail_d   = 1'b0;
      end
      ST_POLL: begin
        if (!busy_i || poll_max) state_d = ST_DECIDE;
        else begin
          poll_inc = 1'b1;
          state_d  = ST_POLL_WAIT;
        end
      end
      ST_POLL_WAIT: if (tick) state_d = ST_POLL;
      ST_DECIDE: begin
        if (busy_i || !sda_s) begin
          state_d   = ST_LOW0;
          pulse_clr = 1'b1;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_LOW0: if (tick) state_d = ST_CHECK;
      ST_CHECK: begin
        if (sda_s || pulse_max) begin
          state_d = ST_RELEASE;
          fail_d  = !sda_s;
        end else begin
          pulse_inc = 1'b1;
          state_d   = ST_HIGH;
        end
      end
      ST_HIGH:    if (tick) state_d = ST_LOW;
      ST_LOW:     if (tick) state_d = ST_CHECK;
      ST_RELEASE: if (tick) state_d = ST_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fail_q  <= fail_d;
    end
  end

  assign pin_sel_o = (state_q == ST_LOW0) || (state_q == ST_CHECK) ||
                     (state_q == ST_HIGH) || (state_q == ST_LOW) ||
                     (state_q == ST_RELEASE);
  assign scl_o     = !((state_q == ST_LOW0) || (state_q == ST_CHECK) ||
                       (state_q == ST_LOW));
  assign done_o    = (state_q == ST_DONE);
  assign fail_o    = fail_q && done_o;

  // R7
  scl_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_sel_o |-> scl_o);

  // R4
  take_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_sel_o) |-> !scl_o);

  // R7
  handback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_sel_o) |-> done_o && $past(scl_o));

  // R8
  fail_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);

  // R9
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_sel_o && start_i |=> state_q != ST_POLL);
endmodule

// File: tb/i2c_hang_recover_tb_top.sv
`timescale 1ns/1ps
module i2c_hang_recover_tb_top;
  localparam int MS   = 4;
  localparam int POLL = 5;
  localparam int MAXP = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic busy_i = 1'b0;
  logic sda_i = 1'b1;
  logic scl_o, pin_sel_o, done_o, fail_o;

  always #2.5 clk_i = ~clk_i;

  i2c_hang_recover #(.MS_CYCLES(MS), .BUSY_POLLS(POLL), .MAX_PULSES(MAXP)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i), .busy_i (busy_i),
    .sda_i (sda_i), .scl_o (scl_o), .pin_sel_o (pin_sel_o),
    .done_o (done_o), .fail_o (fail_o)
  );

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;

  // slave model and phase monitor
  int n_hold = 0;
  int rises = 0, hi_len = 0, lo_len = 0, bad_hi = 0, bad_lo = 0, take_cyc = -1;
  logic prev_scl = 1'b1, prev_sel = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(posedge clk_i) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(negedge clk_i) begin
    if (pin_sel_o && !prev_sel) take_cyc = cyc;
    if (pin_sel_o && scl_o && !prev_scl) begin
      rises++;
      if (lo_len != MS + 1) bad_lo++;   // R4 R5
      lo_len = 0;
    end
    if (prev_sel && prev_scl && (!scl_o || !pin_sel_o)) begin
      if (hi_len != MS) bad_hi++;       // R5 R7
      hi_len = 0;
    end
    if (pin_sel_o && scl_o) hi_len++;
    if (pin_sel_o && !scl_o) lo_len++;
    if (!pin_sel_o) begin hi_len = 0; lo_len = 0; end
    sda_i = (rises >= n_hold);
    prev_scl = scl_o;
    prev_sel = pin_sel_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // busy_len: 0 = never busy, -1 = always busy, else busy for that many cycles
  task automatic run(input int hold, input int busy_len, input bit poke,
                     output int lat, output bit took, output int t_take);
    int t0;
    bit poked;
    poked = 1'b0;
    @(negedge clk_i);
    n_hold = hold; rises = 0; bad_hi = 0; bad_lo = 0; take_cyc = -1;
    sda_i = (hold == 0);
    busy_i = (busy_len != 0);
    start_i = 1'b1;
    t0 = cyc;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 5000) begin
      @(negedge clk_i);
      lat++;
      if (busy_len > 0 && lat >= busy_len) busy_i = 1'b0;
      if (poke && !poked && pin_sel_o && rises == 2) begin
        start_i = 1'b1; poked = 1'b1;
      end else start_i = 1'b0;
    end
    start_i = 1'b0;
    took = (take_cyc >= 0);
    t_take = took ? take_cyc - t0 : -1;
  endtask

  initial begin
    int lat, t_take, expp;
    bit took;
    repeat (3) @(negedge clk_i);
    // R1
    chk(scl_o === 1'b1 && pin_sel_o === 1'b0 && done_o === 1'b0 && fail_o === 1'b0,
        "R1 reset outputs", {scl_o, pin_sel_o, done_o, fail_o}, 4'b1000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // sweep release point, not busy
    for (int n = 0; n <= 12; n++) begin
      run(n, 0, 1'b0, lat, took, t_take);
      chk(done_o === 1'b1, "R7 done reached", done_o, 1);
      chk(pin_sel_o === 1'b0, "R7 pins returned", pin_sel_o, 0);
      chk(took == (n != 0), "R3 takeover on low data line", took, n != 0);
      expp = (n == 0) ? 0 : ((n < MAXP) ? n : MAXP) + 1;
      chk(rises == expp, "R6 pulse count", rises, expp);
      chk(fail_o === (n > MAXP), "R8 fail flag", fail_o, n > MAXP);
      chk(bad_hi == 0, "R5 high phase width", bad_hi, 0);
      chk(bad_lo == 0, "R4 low phase width", bad_lo, 0);
      repeat (3) @(negedge clk_i);
      chk(done_o === 1'b1 && fail_o === (n > MAXP), "R9 done/fail held", done_o, 1);
    end

    // busy never clears
    for (int n = 0; n <= 3; n += 3) begin
      run(n, -1, 1'b0, lat, took, t_take);
      chk(took, "R3 takeover on stuck busy", took, 1);
      chk(t_take >= POLL * MS && t_take <= POLL * (MS + 1) + 4,
          "R3 busy wait length", t_take, POLL * (MS + 1) + 3);
      chk(rises == n + 1, "R6 pulses under busy", rises, n + 1);
      chk(fail_o === 1'b0 && done_o === 1'b1, "R8 no fail", fail_o, 0);
      chk(bad_hi == 0 && bad_lo == 0, "R5 phase widths", bad_hi + bad_lo, 0);
    end

    // busy clears mid-wait, data line high
    for (int k = 2; k <= 17; k += 5) begin
      run(0, k, 1'b0, lat, took, t_take);
      chk(!took, "R2 no takeover after busy clears", took, 0);
      chk(done_o === 1'b1 && fail_o === 1'b0, "R2 clean finish", done_o, 1);
      chk(lat <= k + MS + 6, "R2 latency after busy falls", lat, k + MS + 6);
    end

    // start during recovery
    run(4, 0, 1'b1, lat, took, t_take);
    chk(rises == 5, "R9 start ignored mid recovery", rises, 5);
    chk(done_o === 1'b1 && fail_o === 1'b0, "R9 single completion", done_o, 1);
    repeat (2 * MS) @(negedge clk_i);
    chk(pin_sel_o === 1'b0 && done_o === 1'b1, "R9 no relaunch", pin_sel_o, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule